// File: doc/BRIEF.md
# I2C Target with Clock-Stretch Control

This block is the target (slave) side of a two-wire I2C bus. It watches the synchronized SCL and SDA lines for Start and Stop conditions and shifts in the address byte that follows a Start. It acknowledges that byte if it carries the programmed 7-bit address, or if one of two relaxed modes applies: general-call recognition or accept-all. After an address with the write bit, it receives data bytes and acknowledges each one. After an address with the read bit, it sends bytes from a transmit register, most significant bit first.

Both bus lines are open-drain. The outputs `scl_oe` and `sda_oe` pull the corresponding wire low when high. Clock stretching is governed by a release flag:

- Hardware clears the flag whenever a transmission begins, and the block then holds SCL low until host logic sets the flag again.
- With stretch-enable on, hardware also clears the flag after every received data byte. Host logic may also clear it at will.
- With stretch-enable off, host logic can only set the flag, and reception never stretches.

Every accepted address byte produces a one-cycle interrupt pulse. So does every received data byte, and every master acknowledge that asks for another transmit byte.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe` and `irq` are 0, and `rel_state` is 1.
- R2: An address byte whose upper 7 bits equal `own_addr` is acknowledged, meaning `sda_oe` is high during the ninth clock. It also sets `rx_byte` to the whole address byte, sets `rx_is_addr` to 1, sets `rd_mode` to bit 0 of that byte, and pulses `irq` once.
- R3: An address byte that matches neither `own_addr` nor an enabled mode is not acknowledged and produces no `irq`.
- R4: Address 0x00 is acknowledged, with an `irq` pulse, only while `gc_en` is 1.
- R5: While `take_all` is 1, any address byte is acknowledged.
- R6: After a write address, each data byte is acknowledged. It is captured MSB first into `rx_byte`, with `rx_is_addr` at 0 and one `irq` pulse.
- R7: While `hold_en` is 1, `rel_state` is cleared after each received data byte, and SCL is held low after the ninth clock falls. The hold ends one clock after `rel_set` raises `rel_state`, which happens on the clock edge that samples `rel_set`. While `hold_en` is 1, `rel_clr` clears `rel_state`.
- R8: While `hold_en` is 0, `rel_clr` has no effect on `rel_state`, and reception never holds SCL.
- R9: After a read address, `rel_state` is cleared and SCL is held low until `rel_set`. The block then drives `tx_byte` MSB first on the following eight clocks.
- R10: In transmit, a master acknowledge (SDA low on the ninth clock) starts the next byte with `rel_state` cleared, SCL held, and one `irq` pulse. A master NACK returns the block to idle, so it drives no data until the next Start.
- R11: A Stop or a new Start at any point aborts the current byte. After a Stop, address bits clocked without a Start are ignored. After a repeated Start, a new address byte is matched normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe | output | 1 | Pull SCL low (stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge or data 0) |
| own_addr | input | 7 | Programmed 7-bit target address |
| gc_en | input | 1 | Acknowledge address 0x00 |
| take_all | input | 1 | Acknowledge every address |
| hold_en | input | 1 | Stretch enable for reception and software stretching |
| rel_set | input | 1 | One-cycle pulse: set the release flag |
| rel_clr | input | 1 | One-cycle pulse: clear the release flag (only with `hold_en`) |
| rel_state | output | 1 | Current release flag |
| tx_byte | input | 8 | Byte to transmit |
| rx_byte | output | 8 | Last address or data byte received |
| rx_is_addr | output | 1 | 1 when `rx_byte` holds an address byte |
| rd_mode | output | 1 | Read/write bit of the last accepted address |
| irq | output | 1 | One-cycle event pulse |

## Verification
The bench aims first at the release flag's timing. A hold that dropped on the same cycle as `rel_set`, or never dropped, would show up on `scl_oe` in the cycle straddling the write. It also checks that a soft clear with stretch-enable off is ignored, since a design that honoured it would stretch a plain write transfer. Address corners cover general call with its enable both off and on, accept-all with a foreign address, and a mismatch. A loose comparator there would acknowledge when it should stay silent. Transmit checks that a NACK truly idles the block, because a design that kept shifting would corrupt the bus with data bits. Finally, a Stop or repeated Start mid-byte must reset bit counting, or the next address would be misaligned.

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [6:0] own_addr,
  input  logic       gc_en,
  input  logic       take_all,
  input  logic       hold_en,
  input  logic       rel_set,
  input  logic       rel_clr,
  output logic       rel_state,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  output logic       rx_is_addr,
  output logic       rd_mode,
  output logic       irq
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK} st_t;

  st_t        st;
  logic [2:0] scl_q, sda_q;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       hold, rel, mack;

  wire scl_s  = scl_q[1];
  wire scl_p  = scl_q[2];
  wire sda_s  = sda_q[1];
  wire sda_p  = sda_q[2];
  wire rise   = scl_s & ~scl_p;
  wire fall   = ~scl_s & scl_p;
  wire start_c = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  wire addr_hit = take_all | (sh[7:1] == own_addr) | (gc_en & (sh[7:1] == 7'd0));

  assign scl_oe    = hold;
  assign rel_state = rel;

  always_comb begin
    case (st)
      S_AACK, S_RACK: sda_oe = 1'b1;
      S_TX:           sda_oe = ~sh[7];
      default:        sda_oe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      sh         <= '0;
      cnt        <= '0;
      hold       <= 1'b0;
      rel        <= 1'b1;
      mack       <= 1'b1;
      rx_byte    <= '0;
      rx_is_addr <= 1'b0;
      rd_mode    <= 1'b0;
      irq        <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (rel_set)                 rel <= 1'b1;
      else if (rel_clr && hold_en) rel <= 1'b0;
      if (hold && rel) hold <= 1'b0;

      if (stop_c) begin
        st   <= S_IDLE;
        hold <= 1'b0;
      end else if (start_c) begin
        st   <= S_ADDR;
        cnt  <= '0;
        hold <= 1'b0;
      end else begin
        if (fall && hold_en && !rel && !rel_set && (st == S_RX || st == S_TX))
          hold <= 1'b1;
        case (st)
          S_ADDR, S_RX: begin
            if (rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == S_RX) begin
                st         <= S_RACK;
                rx_byte    <= sh;
                rx_is_addr <= 1'b0;
                irq        <= 1'b1;
              end else if (addr_hit) begin
                st         <= S_AACK;
                rx_byte    <= sh;
                rx_is_addr <= 1'b1;
                rd_mode    <= sh[0];
                irq        <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_AACK: if (fall) begin
            if (rd_mode) begin
              st   <= S_TX;
              sh   <= tx_byte;
              rel  <= 1'b0;
              hold <= 1'b1;
            end else begin
              st <= S_RX;
            end
          end
          S_RACK: if (fall) begin
            st <= S_RX;
            if (hold_en) begin
              rel  <= 1'b0;
              hold <= 1'b1;
            end
          end
          S_TX: begin
            if (hold && cnt == 4'd0) sh <= tx_byte;
            if (fall) begin
              if (cnt == 4'd7) begin
                st  <= S_TACK;
                cnt <= '0;
              end else begin
                sh  <= {sh[6:0], 1'b1};
                cnt <= cnt + 4'd1;
              end
            end
          end
          S_TACK: begin
            if (rise) mack <= sda_s;
            if (fall) begin
              if (!mack) begin
                st   <= S_TX;
                sh   <= tx_byte;
                rel  <= 1'b0;
                hold <= 1'b1;
                irq  <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module i2c_target_stretch_chk (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic scl_oe,
  input logic rel_state,
  input logic hold_en,
  input logic rd_mode
);

  a_r2_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r7_release_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && rel_state) |=> !scl_oe);

  a_r9_hold_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !rel_state);

  a_r8_no_rx_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_en && $rose(scl_oe)) |-> rd_mode);

endmodule

bind i2c_target_stretch i2c_target_stretch_chk chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .scl_oe(scl_oe),
  .rel_state(rel_state), .hold_en(hold_en), .rd_mode(rd_mode)
);

// File: tb/i2c_target_stretch_test.sv
module i2c_target_stretch_test;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic [6:0] own_addr = 7'h2A;
  logic gc_en = 1'b0, take_all = 1'b0, hold_en = 1'b0;
  logic rel_set = 1'b0, rel_clr = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic scl_oe, sda_oe, rel_state, rx_is_addr, rd_mode, irq;
  logic [7:0] rx_byte;
  int checks = 0, fails = 0, irq_n = 0;
  bit done = 0;

  wire scl_bus = ~(m_scl_low | scl_oe);
  wire sda_bus = ~(m_sda_low | sda_oe);

  always #4 clk = ~clk;

  i2c_target_stretch uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .gc_en(gc_en),
    .take_all(take_all), .hold_en(hold_en), .rel_set(rel_set), .rel_clr(rel_clr),
    .rel_state(rel_state), .tx_byte(tx_byte), .rx_byte(rx_byte),
    .rx_is_addr(rx_is_addr), .rd_mode(rd_mode), .irq(irq)
  );

  always @(posedge clk) if (rst_n && irq) irq_n++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    m_sda_low = 1'b1; w(Q);
    m_scl_low = 1'b1; w(Q);
  endtask

  task automatic m_stop;
    m_sda_low = 1'b1; w(Q);
    m_scl_low = 1'b0; wait (scl_bus); w(Q);
    m_sda_low = 1'b0; w(2*Q);
  endtask

  task automatic m_rstart;
    m_sda_low = 1'b0; w(Q);
    m_scl_low = 1'b0; wait (scl_bus); w(Q);
    m_sda_low = 1'b1; w(Q);
    m_scl_low = 1'b1; w(Q);
  endtask

  task automatic m_bit(input logic b, output logic r);
    m_sda_low = ~b; w(Q);
    m_scl_low = 1'b0; wait (scl_bus); w(Q);
    r = sda_bus; w(Q);
    m_scl_low = 1'b1; w(Q);
  endtask

  task automatic m_byte(input logic [7:0] d, output logic ackb);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, ackb);
  endtask

  task automatic m_read(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      d[i] = r;
    end
    m_bit(~give_ack, r);
  endtask

  task automatic pulse_set;
    rel_set = 1'b1; w(1); rel_set = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rel_state", rel_state, 1);
  endtask

  task automatic t_addr_mismatch;
    logic a; int i0 = irq_n;
    m_start; m_byte({7'h2B, 1'b0}, a);
    chk("R3 no ack", a, 1);
    chk("R3 no irq", irq_n - i0, 0);
    m_stop;
  endtask

  task automatic t_general_call;
    logic a; int i0;
    gc_en = 1'b0; i0 = irq_n;
    m_start; m_byte(8'h00, a);
    chk("R4 gc off no ack", a, 1);
    chk("R4 gc off no irq", irq_n - i0, 0);
    m_stop;
    gc_en = 1'b1; i0 = irq_n;
    m_start; m_byte(8'h00, a);
    chk("R4 gc on ack", a, 0);
    chk("R4 gc on irq", irq_n - i0, 1);
    m_stop;
    gc_en = 1'b0;
  endtask

  task automatic t_take_all;
    logic a;
    take_all = 1'b1;
    m_start; m_byte(8'hDC, a);
    chk("R5 foreign address acked", a, 0);
    chk("R5 rx_byte", rx_byte, 8'hDC);
    m_stop;
    take_all = 1'b0;
  endtask

  task automatic t_write_plain;
    logic a; int i0;
    hold_en = 1'b0; i0 = irq_n;
    m_start; m_byte(8'h54, a);
    chk("R2 ack", a, 0);
    chk("R2 rx_byte", rx_byte, 8'h54);
    chk("R2 rx_is_addr", rx_is_addr, 1);
    chk("R2 rd_mode", rd_mode, 0);
    chk("R2 irq once", irq_n - i0, 1);
    m_byte(8'h96, a);
    chk("R6 data ack", a, 0);
    chk("R6 rx_byte", rx_byte, 8'h96);
    chk("R6 rx_is_addr", rx_is_addr, 0);
    chk("R6 irq", irq_n - i0, 2);
    chk("R8 no stretch", scl_oe, 0);
    chk("R8 rel kept", rel_state, 1);
    rel_clr = 1'b1; w(1); rel_clr = 1'b0; w(2);
    chk("R8 rel_clr ignored", rel_state, 1);
    m_byte(8'h01, a);
    chk("R8 next byte unstretched", rx_byte, 8'h01);
    m_stop;
  endtask

  task automatic t_write_stretch;
    logic a;
    hold_en = 1'b1;
    m_start; m_byte(8'h54, a);
    chk("R7 no stretch after address", scl_oe, 0);
    m_byte(8'h5A, a);
    chk("R7 rx_byte", rx_byte, 8'h5A);
    chk("R7 rel cleared", rel_state, 0);
    chk("R7 scl held", scl_oe, 1);
    rel_set = 1'b1; w(1); rel_set = 1'b0;
    chk("R7 still held one clock", scl_oe, 1);
    w(1);
    chk("R7 released", scl_oe, 0);
    rel_clr = 1'b1; w(1); rel_clr = 1'b0;
    chk("R7 rel_clr works", rel_state, 0);
    pulse_set;
    m_byte(8'hC3, a);
    chk("R7 second byte", rx_byte, 8'hC3);
    chk("R7 second stretch", scl_oe, 1);
    pulse_set; w(2);
    m_stop;
    hold_en = 1'b0;
  endtask

  task automatic t_read;
    logic a; logic [7:0] d; int i0;
    tx_byte = 8'hA5;
    m_start; m_byte(8'h55, a);
    chk("R9 read ack", a, 0);
    chk("R9 rd_mode", rd_mode, 1);
    chk("R9 rel cleared", rel_state, 0);
    chk("R9 scl held", scl_oe, 1);
    pulse_set; w(2);
    i0 = irq_n;
    m_read(1'b1, d);
    chk("R9 tx data", d, 8'hA5);
    chk("R10 held after ack", scl_oe, 1);
    chk("R10 irq on ack", irq_n - i0, 1);
    tx_byte = 8'h3C;
    pulse_set; w(2);
    m_read(1'b0, d);
    chk("R10 second byte", d, 8'h3C);
    chk("R10 no hold after nack", scl_oe, 0);
    m_read(1'b0, d);
    chk("R10 idle after nack", d, 8'hFF);
    m_stop;
  endtask

  task automatic t_abort;
    logic a, r; int i0;
    m_start;
    m_bit(1'b0, r); m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b1, r);
    m_stop;
    i0 = irq_n;
    m_scl_low = 1'b1; w(Q);
    m_byte(8'h54, a);
    chk("R11 ignored after stop", a, 1);
    chk("R11 no irq after stop", irq_n - i0, 0);
    m_scl_low = 1'b0; w(2*Q);
    m_start;
    m_bit(1'b1, r); m_bit(1'b1, r); m_bit(1'b0, r);
    m_rstart;
    m_byte(8'h54, a);
    chk("R11 ack after repeated start", a, 0);
    chk("R11 rx_byte after repeated start", rx_byte, 8'h54);
    m_stop;
  endtask

  initial begin
    w(5); rst_n = 1'b1; w(5);
    t_reset;
    t_write_plain;
    t_addr_mismatch;
    t_general_call;
    t_take_all;
    t_write_stretch;
    t_read;
    t_abort;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule